// File: doc/BRIEF.md
# Conversion Start and Power-Down Sequencer

This block is the control logic for a successive-approximation converter. It sequences the track/hold select, times the conversion and settling intervals, and decides after each conversion whether the converter stays powered or goes to sleep. The bit-trial datapath and the analog circuits are outside this block; they follow the `hold` and `pdown` outputs, and the `ready` pulse tells the datapath when to latch its result.

A conversion begins on a falling edge of the active-low start pin or on a one-cycle software start strobe. Hold then stays asserted for a fixed number of system clocks, computed from the clock frequency and the conversion time. In the cycle after hold drops, `ready` pulses and the power decision takes effect. If the start pin is low at that moment, or the software sleep level is high, the block sleeps. Otherwise it spends a short settling interval before it returns to tracking. A start request that arrives while the block sleeps first runs a wake-up delay and then converts. The reference-amplifier-off flag is set whenever an external reference is selected or the block sleeps.

Top module: `cs_seq`

## Requirements
- R1: After reset, `hold`, `busy`, `pdown` and `ready` are all low. The block is tracking and powered.
- R2: While tracking and not busy, a falling edge of `conv_n` (high in one cycle, low in the next) asserts `hold` and `busy` in the following cycle.
- R3: While tracking, a one-cycle high on `sw_start` asserts `hold` and `busy` in the following cycle.
- R4: `hold` stays high for exactly CONV_CYC consecutive cycles, where CONV_CYC = (CONV_NS*CLK_MHZ+999)/1000. This is 115 cycles at the defaults of 50 MHz and 2300 ns.
- R5: `ready` is high for exactly one cycle, which is the first cycle in which `hold` is low after a conversion.
- R6: If `conv_n` is high and `sw_pdown` is low in the last hold cycle, `pdown` stays low. `busy` then stays high for SETTLE_CYC = (SETTLE_NS*CLK_MHZ+999)/1000 cycles (5 at the defaults), counted from the `ready` cycle, after which the block tracks.
- R7: If `conv_n` is low or `sw_pdown` is high in the last hold cycle, `pdown` rises in the same cycle as `ready`, and `busy` is low.
- R8: `sw_pdown` high while tracking idle asserts `pdown` in the next cycle. `pdown` remains set after `sw_pdown` falls, until a start request arrives.
- R9: Start requests (edges of `conv_n` or `sw_start` strobes) that arrive while `busy` is high are ignored. None is queued: after settling the block tracks with `hold` low.
- R10: A start request while `pdown` is high clears `pdown` in the next cycle. `busy` is then high with `hold` low for WAKE_CYC cycles (20 by default), after which `hold` rises.
- R11: `ref_off` is high whenever `ext_ref` is high or `pdown` is high, and low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| conv_n | input | 1 | Active-low convert-start pin; falling edge starts, level at end selects sleep |
| sw_start | input | 1 | One-cycle software convert-start strobe |
| sw_pdown | input | 1 | Software sleep level |
| ext_ref | input | 1 | External reference selected |
| hold | output | 1 | 1 = hold (converting), 0 = track |
| busy | output | 1 | Wake-up, conversion or settling in progress |
| pdown | output | 1 | Converter powered down |
| ready | output | 1 | One-cycle result-ready pulse |
| ref_off | output | 1 | Internal reference amplifier powered down |

## Verification
The hardest situation to reach is a start request that lands while the block is busy. This case matters most when it coincides with the decision cycle, where the pin level rather than its edge counts. The directed part toggles `conv_n` and strobes `sw_start` in the middle of conversions, and drives the pin low just before a conversion ends. The random part biases pin toggles and strobes so they land in every state, including wake-up and settling, and compares each cycle against a bench model of the sequence.

// File: rtl/cs_seq_pkg.sv
`timescale 1ns/1ps
package cs_seq_pkg;
   typedef enum logic [2:0] {
      ST_TRACK  = 3'd0,
      ST_WAKE   = 3'd1,
      ST_CONV   = 3'd2,
      ST_SETTLE = 3'd3,
      ST_SLEEP  = 3'd4
   } seq_state_t;

   // Clock cycles covering a time in ns at a clock in MHz (rounded up)
   function automatic int ns_to_cycles(input int ns, input int mhz);
      return (ns * mhz + 999) / 1000;
   endfunction
endpackage

// File: rtl/cs_edge_sync.sv
`timescale 1ns/1ps
module cs_edge_sync #(
   parameter int STAGES = 0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin_in,
   output logic level_o,
   output logic fall_o
);
   logic prev_q;

   generate
      if (STAGES == 0) begin : g_direct
         assign level_o = pin_in;
      end else begin : g_sync
         logic [STAGES-1:0] chain_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q <= '1;
            else        chain_q <= {chain_q[STAGES-2:0], pin_in};
         end
         assign level_o = chain_q[STAGES-1];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= 1'b1;
      else        prev_q <= level_o;
   end

   assign fall_o = prev_q & ~level_o;
endmodule

// File: rtl/cs_interval_timer.sv
`timescale 1ns/1ps
module cs_interval_timer #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] load_val,
   output logic         expired
);
   logic [W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           cnt_q <= '0;
      else if (load)        cnt_q <= load_val;
      else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
   end

   assign expired = (cnt_q == '0);
endmodule

// File: rtl/cs_seq.sv
`timescale 1ns/1ps
module cs_seq
   import cs_seq_pkg::*;
#(
   parameter int CLK_MHZ     = 50,
   parameter int CONV_NS     = 2300,
   parameter int SETTLE_NS   = 100,
   parameter int WAKE_CYC    = 20,
   parameter int SYNC_STAGES = 0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic conv_n,
   input  logic sw_start,
   input  logic sw_pdown,
   input  logic ext_ref,
   output logic hold,
   output logic busy,
   output logic pdown,
   output logic ready,
   output logic ref_off
);
   localparam int CONV_CYC   = ns_to_cycles(CONV_NS, CLK_MHZ);
   localparam int SETTLE_CYC = ns_to_cycles(SETTLE_NS, CLK_MHZ);
   localparam int MAX_A      = (CONV_CYC > SETTLE_CYC) ? CONV_CYC : SETTLE_CYC;
   localparam int MAX_CYC    = (MAX_A > WAKE_CYC) ? MAX_A : WAKE_CYC;
   localparam int TW         = $clog2(MAX_CYC + 1);

   generate
      if (CLK_MHZ < 1)     begin : g_bad_clk    $error("CLK_MHZ must be positive"); end
      if (CONV_CYC < 2)    begin : g_bad_conv   $error("conversion must span 2+ cycles"); end
      if (SETTLE_CYC < 1)  begin : g_bad_settle $error("settling must span 1+ cycle"); end
      if (WAKE_CYC < 1)    begin : g_bad_wake   $error("WAKE_CYC must be 1 or more"); end
      if (SYNC_STAGES < 0 || SYNC_STAGES == 1)
                           begin : g_bad_sync   $error("SYNC_STAGES must be 0 or 2+"); end
   endgenerate

   seq_state_t    state_q, state_d;
   logic          ready_q, ready_d;
   logic          pin_lvl, pin_fall, start_req, sleep_now;
   logic          tmr_load, tmr_done;
   logic [TW-1:0] tmr_val;

   cs_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .pin_in  (conv_n),
      .level_o (pin_lvl),
      .fall_o  (pin_fall)
   );

   cs_interval_timer #(.W(TW)) u_tmr (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (tmr_load),
      .load_val (tmr_val),
      .expired  (tmr_done)
   );

   assign start_req = pin_fall | sw_start;
   assign sleep_now = ~pin_lvl | sw_pdown;

   always_comb begin
      state_d  = state_q;
      ready_d  = 1'b0;
      tmr_load = 1'b0;
      tmr_val  = '0;
      unique case (state_q)
         ST_TRACK: begin
            if (start_req) begin
               state_d  = ST_CONV;
               tmr_load = 1'b1;
               tmr_val  = TW'(CONV_CYC - 1);
            end else if (sw_pdown) begin
               state_d = ST_SLEEP;
            end
         end
         ST_SLEEP: begin
            if (start_req) begin
               state_d  = ST_WAKE;
               tmr_load = 1'b1;
               tmr_val  = TW'(WAKE_CYC - 1);
            end
         end
         ST_WAKE: begin
            if (tmr_done) begin
               state_d  = ST_CONV;
               tmr_load = 1'b1;
               tmr_val  = TW'(CONV_CYC - 1);
            end
         end
         ST_CONV: begin
            if (tmr_done) begin
               ready_d = 1'b1;
               if (sleep_now) begin
                  state_d = ST_SLEEP;
               end else begin
                  state_d  = ST_SETTLE;
                  tmr_load = 1'b1;
                  tmr_val  = TW'(SETTLE_CYC - 1);
               end
            end
         end
         ST_SETTLE: begin
            if (tmr_done) state_d = ST_TRACK;
         end
         default: state_d = ST_TRACK;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_TRACK;
         ready_q <= 1'b0;
      end else begin
         state_q <= state_d;
         ready_q <= ready_d;
      end
   end

   assign hold    = (state_q == ST_CONV);
   assign busy    = (state_q == ST_WAKE) || (state_q == ST_CONV) || (state_q == ST_SETTLE);
   assign pdown   = (state_q == ST_SLEEP);
   assign ready   = ready_q;
   assign ref_off = ext_ref | pdown;
endmodule

// File: rtl/cs_seq_chk.sv
`timescale 1ns/1ps
module cs_seq_chk #(
   parameter int CLK_MHZ = 50,
   parameter int CONV_NS = 2300
) (
   input logic clk,
   input logic rst_n,
   input logic sw_pdown,
   input logic ext_ref,
   input logic hold,
   input logic busy,
   input logic pdown,
   input logic ready,
   input logic ref_off
);
   localparam int CONV_CYC = (CONV_NS * CLK_MHZ + 999) / 1000;
   localparam int RW       = $clog2(CONV_CYC + 2);

   logic [RW-1:0] run_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     run_q <= '0;
      else if (!hold) run_q <= '0;
      else            run_q <= run_q + 1'b1;
   end

   // R4
   hold_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
      run_q <= RW'(CONV_CYC));

   // R4
   hold_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hold |-> busy);

   // R5
   ready_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ready |=> !ready);

   // R5
   ready_after_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ready |-> (!hold && $past(hold)));

   // R7
   sleep_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(pdown && busy));

   // R8
   sleep_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pdown) |-> (ready || $past(sw_pdown)));

   // R11
   ref_sleep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pdown || ext_ref) |-> ref_off);
endmodule

bind cs_seq cs_seq_chk #(.CLK_MHZ(CLK_MHZ), .CONV_NS(CONV_NS)) u_cs_seq_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .sw_pdown (sw_pdown),
   .ext_ref  (ext_ref),
   .hold     (hold),
   .busy     (busy),
   .pdown    (pdown),
   .ready    (ready),
   .ref_off  (ref_off)
);

// File: tb/tb_cs_seq.sv
`timescale 1ns/1ps
module tb_cs_seq;
   localparam int CONV_C   = 115;
   localparam int SETTLE_C = 5;
   localparam int WAKE_C   = 20;
   localparam int M_TRACK = 0, M_WAKE = 1, M_CONV = 2, M_SETTLE = 3, M_SLEEP = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic conv_n = 1'b1, sw_start = 1'b0, sw_pdown = 1'b0, ext_ref = 1'b0;
   logic hold, busy, pdown, ready, ref_off;

   int errors = 0;
   int checks = 0;
   bit done = 1'b0;

   int m_st = M_TRACK;
   int m_left = 0;
   bit m_prev = 1'b1;
   bit m_ready = 1'b0;

   always #10 clk = ~clk;

   cs_seq dut (
      .clk(clk), .rst_n(rst_n), .conv_n(conv_n), .sw_start(sw_start),
      .sw_pdown(sw_pdown), .ext_ref(ext_ref), .hold(hold), .busy(busy),
      .pdown(pdown), .ready(ready), .ref_off(ref_off)
   );

   task automatic chk(input string tag, input logic got, input logic exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s: got %b expected %b at %0t", tag, got, exp, $time);
      end
   endtask

   task automatic chk_int(input string tag, input int got, input int exp);
      checks++;
      if (got != exp) begin
         errors++;
         $display("FAIL %s: got %0d expected %0d at %0t", tag, got, exp, $time);
      end
   endtask

   // Bench model of the requirements, advanced once per clock
   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_st = M_TRACK; m_left = 0; m_prev = 1'b1; m_ready = 1'b0;
      end else begin
         bit go;
         go = (m_prev && !conv_n) || sw_start;
         m_ready = 1'b0;
         case (m_st)
            M_TRACK:  if (go) begin m_st = M_CONV; m_left = CONV_C; end
                      else if (sw_pdown) m_st = M_SLEEP;
            M_SLEEP:  if (go) begin m_st = M_WAKE; m_left = WAKE_C; end
            M_WAKE:   if (m_left == 1) begin m_st = M_CONV; m_left = CONV_C; end
                      else m_left--;
            M_CONV:   if (m_left == 1) begin
                         m_ready = 1'b1;
                         if (!conv_n || sw_pdown) m_st = M_SLEEP;
                         else begin m_st = M_SETTLE; m_left = SETTLE_C; end
                      end else m_left--;
            default:  if (m_left == 1) m_st = M_TRACK; else m_left--;
         endcase
         m_prev = conv_n;
      end
   end

   // Cycle-by-cycle comparison with the model
   always @(negedge clk) begin
      if (rst_n && !done) begin
         chk("R4 model hold", hold, m_st == M_CONV);
         chk("R10 model busy", busy, m_st == M_WAKE || m_st == M_CONV || m_st == M_SETTLE);
         chk("R7 model pdown", pdown, m_st == M_SLEEP);
         chk("R5 model ready", ready, m_ready);
         chk("R11 model ref_off", ref_off, ext_ref || m_st == M_SLEEP);
      end
   end

   initial begin
      #(100000 * 20);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      int n;
      void'($urandom(32'd4242));
      repeat (3) @(negedge clk);
      // R1 reset state
      chk("R1 hold", hold, 1'b0);
      chk("R1 busy", busy, 1'b0);
      chk("R1 pdown", pdown, 1'b0);
      chk("R1 ready", ready, 1'b0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      // R2: pin falling edge starts; R9 edges during conversion ignored
      conv_n = 1'b0;
      @(negedge clk);
      chk("R2 hold", hold, 1'b1);
      chk("R2 busy", busy, 1'b1);
      n = 0;
      while (hold && n < 500) begin
         n++;
         if (n == 10) conv_n = 1'b1;
         if (n == 20) conv_n = 1'b0;
         if (n == 30) sw_start = 1'b1;
         if (n == 31) sw_start = 1'b0;
         if (n == 40) conv_n = 1'b1;
         @(negedge clk);
      end
      chk_int("R4 hold length", n, CONV_C);
      chk("R5 ready pulse", ready, 1'b1);
      chk("R6 stays powered", pdown, 1'b0);
      chk("R6 settling busy", busy, 1'b1);
      @(negedge clk);
      chk("R5 ready drops", ready, 1'b0);
      repeat (SETTLE_C - 2) @(negedge clk);
      chk("R6 last settle cycle", busy, 1'b1);
      @(negedge clk);
      chk("R6 tracking", busy, 1'b0);
      chk("R9 no queued start", hold, 1'b0);
      repeat (3) @(negedge clk);

      // R3: software strobe starts; end with pin low -> sleep (R7)
      sw_start = 1'b1;
      @(negedge clk);
      sw_start = 1'b0;
      chk("R3 hold", hold, 1'b1);
      chk("R3 busy", busy, 1'b1);
      n = 0;
      while (hold && n < 500) begin
         n++;
         if (n == 5) conv_n = 1'b0;
         @(negedge clk);
      end
      chk_int("R4 hold length sw", n, CONV_C);
      chk("R7 ready with sleep", ready, 1'b1);
      chk("R7 pdown", pdown, 1'b1);
      chk("R7 not busy", busy, 1'b0);
      chk("R11 ref off asleep", ref_off, 1'b1);
      repeat (3) @(negedge clk);

      // R10: wake from sleep by strobe; rising pin alone does nothing
      conv_n = 1'b1;
      repeat (2) @(negedge clk);
      chk("R10 rise no wake", pdown, 1'b1);
      sw_start = 1'b1;
      @(negedge clk);
      sw_start = 1'b0;
      chk("R10 pdown cleared", pdown, 1'b0);
      n = 0;
      while (busy && !hold && n < 500) begin
         n++;
         @(negedge clk);
      end
      chk_int("R10 wake length", n, WAKE_C);
      chk("R10 then hold", hold, 1'b1);
      while (busy) @(negedge clk);
      chk("R6 powered after wake", pdown, 1'b0);

      // R8: software sleep from idle, persists after release
      sw_pdown = 1'b1;
      @(negedge clk);
      chk("R8 pdown", pdown, 1'b1);
      sw_pdown = 1'b0;
      repeat (3) @(negedge clk);
      chk("R8 persists", pdown, 1'b1);
      conv_n = 1'b0;
      @(negedge clk);
      conv_n = 1'b1;
      chk("R10 pin wake", pdown, 1'b0);
      while (busy) @(negedge clk);
      ext_ref = 1'b1;
      @(negedge clk);
      chk("R11 ext ref", ref_off, 1'b1);
      ext_ref = 1'b0;
      @(negedge clk);
      chk("R11 ref on", ref_off, 1'b0);

      // Random phase, checked by the model (R9 and all others)
      for (int i = 0; i < 12000; i++) begin
         if ($urandom_range(7) == 0) conv_n = ~conv_n;
         sw_start = ($urandom_range(39) == 0);
         if ($urandom_range(199) == 0) sw_pdown = ~sw_pdown;
         if ($urandom_range(49) == 0) ext_ref = ~ext_ref;
         @(negedge clk);
      end
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule